// File: doc/BRIEF.md
# Programmable-Width CRC Step Unit

This block advances a cyclic redundancy check of runtime-selected width over a short chunk of input bits. A single request carries three 32-bit words: a control word that sets the remainder width, the generator polynomial, the chunk length, a bit-order flag and an inversion flag; a data word whose low bits form the chunk; and a seed word that holds the running remainder. The block returns the updated remainder, zero-extended to 32 bits, ready to be fed back as the seed of the next request.

The unit is iterative. A request is taken when `req_valid` and `req_ready` are both high. The unit then spends one clock per chunk bit on polynomial division, holds `req_ready` low for that time, and raises `done` for exactly one cycle with the new remainder on `result`. Requests offered while it is busy are not taken. The asynchronous reset is released to the logic through an internal two-stage synchronizer.

Control word fields used by the block: bits [2:0] hold chunk length minus one, bit 8 selects reversed bit order of the chunk, bit 9 selects inversion, bits [15:12] hold remainder width minus one, and bits [31:16] hold the polynomial. All other control bits are ignored.

Top module: `crcn_step_unit`

## Requirements
- R1: The remainder width n is control bits [15:12] plus one (1 to 16); on every `done`, `result` bits n and above are zero.
- R2: The polynomial is the low n bits of control bits [31:16]; the x^n term is implied and not stored.
- R3: The chunk length m is control bits [2:0] plus one (1 to 8); data bits m and above do not change the result.
- R4: When control bit 8 is set, the m chunk bits are reversed end for end within their m-bit field before use; data 0x01 reversed with m = 8 gives the same result as data 0x80 not reversed.
- R5: When control bit 9 is set, the low n bits of the seed are complemented before division and the final remainder is complemented before masking to n bits.
- R6: The starting remainder is the seed XOR the chunk aligned to n bits (shifted right by m−n when m > n, else left by n−m); then m steps each shift the remainder left, insert into bit 0 the next bit of a copy of the chunk pre-shifted left by n (taken from its bit m−1, then the copy shifts left), and XOR the polynomial when the old bit n−1 was one.
- R7: `req_ready` is high whenever the unit is idle and out of reset; after a request is taken it stays low for m cycles, and requests offered during that time are ignored.
- R8: `done` rises exactly m clock cycles after the accepting edge, for one cycle; `result` changes only together with `done` and holds until the next one.
- R9: While reset is applied, `done` and `result` are zero; after reset is released and synchronized, `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request will be taken |
| ctrl | input | 32 | Control word (width, polynomial, chunk length, flags) |
| data | input | 32 | Chunk bits in the low positions |
| seed | input | 32 | Incoming remainder in the low n bits |
| done | output | 1 | One-cycle strobe, result valid |
| result | output | 32 | Updated remainder, zero-extended |

## Verification
The division is tried over every width from 1 to 16 against every chunk length from 1 to 8, with all four flag combinations and random polynomials, chunks and seeds, so the cases where data enters only through the starting alignment (m ≤ n) are told apart from those where it is also shifted in bit by bit (m > n). A hand-worked all-ones remainder with inversion separates the feedback XOR from the final complement, and a single-bit chunk at opposite ends separates the reversed order from the plain one. Garbage above the chunk and a second request held during the busy window show that those inputs reach neither the result nor the handshake.

// File: rtl/crcn_pkg.sv
package crcn_pkg;
  localparam int WORD_W    = 32;
  localparam int CRC_MAX   = 16;
  localparam int CHUNK_MAX = 8;

  // field positions decoded from the control word
  localparam int CHUNK_LSB = 0;
  localparam int CHUNK_FW  = $clog2(CHUNK_MAX);
  localparam int REV_BIT   = 8;
  localparam int INV_BIT   = 9;
  localparam int WIDTH_LSB = 12;
  localparam int WIDTH_FW  = $clog2(CRC_MAX);
  localparam int POLY_LSB  = 16;

  localparam int NW  = $clog2(CRC_MAX) + 1;
  localparam int MW  = $clog2(CHUNK_MAX) + 1;
  localparam int ALW = CRC_MAX + CHUNK_MAX;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} crcn_state_e;

  typedef struct packed {
    logic [CRC_MAX-1:0]   rem;
    logic [CRC_MAX-1:0]   poly;
    logic [CRC_MAX-1:0]   mask;
    logic [CRC_MAX-1:0]   top;
    logic [CHUNK_MAX-1:0] feed;
    logic [MW-1:0]        left;
    logic                 inv;
  } crcn_job_t;
endpackage

// File: rtl/crcn_rst_sync.sv
module crcn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/crcn_cfg_decode.sv
module crcn_cfg_decode
  import crcn_pkg::*;
(
  input  logic [WORD_W-1:0] ctrl_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] seed_i,
  output crcn_job_t         job_o
);
  logic [NW-1:0]        n_w;
  logic [MW-1:0]        m_w;
  logic [CRC_MAX-1:0]   mask_w;
  logic [CHUNK_MAX-1:0] cmask_w;
  logic [CHUNK_MAX-1:0] chunk_w;
  logic [CHUNK_MAX-1:0] flip_w;
  logic [CHUNK_MAX-1:0] used_w;
  logic [CRC_MAX-1:0]   seed_w;
  logic [ALW-1:0]       wide_w;
  logic [ALW-1:0]       aligned_w;
  logic [ALW-1:0]       pre_w;
  logic                 rev_w;
  logic                 inv_w;

  always_comb begin
    n_w   = NW'(ctrl_i[WIDTH_LSB +: WIDTH_FW]) + NW'(1);
    m_w   = MW'(ctrl_i[CHUNK_LSB +: CHUNK_FW]) + MW'(1);
    rev_w = ctrl_i[REV_BIT];
    inv_w = ctrl_i[INV_BIT];

    mask_w  = {CRC_MAX{1'b1}} >> (NW'(CRC_MAX) - n_w);
    cmask_w = {CHUNK_MAX{1'b1}} >> (MW'(CHUNK_MAX) - m_w);
    chunk_w = data_i[CHUNK_MAX-1:0] & cmask_w;

    for (int i = 0; i < CHUNK_MAX; i++) begin
      flip_w[i] = chunk_w[CHUNK_MAX-1-i];
    end
    used_w = rev_w ? (flip_w >> (MW'(CHUNK_MAX) - m_w)) : chunk_w;

    seed_w = (inv_w ? ~seed_i[CRC_MAX-1:0] : seed_i[CRC_MAX-1:0]) & mask_w;

    wide_w = {{CRC_MAX{1'b0}}, used_w};
    if (NW'(m_w) > n_w) aligned_w = wide_w >> (NW'(m_w) - n_w);
    else                aligned_w = wide_w << (n_w - NW'(m_w));

    pre_w = wide_w << n_w;

    job_o.rem  = aligned_w[CRC_MAX-1:0] ^ seed_w;
    job_o.poly = ctrl_i[POLY_LSB +: CRC_MAX] & mask_w;
    job_o.mask = mask_w;
    job_o.top  = CRC_MAX'(1) << (n_w - NW'(1));
    job_o.feed = pre_w[CHUNK_MAX-1:0] << (MW'(CHUNK_MAX) - m_w);
    job_o.left = m_w;
    job_o.inv  = inv_w;
  end
endmodule

// File: rtl/crcn_div_step.sv
module crcn_div_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] poly_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] top_i,
  input  logic         bit_i,
  output logic [W-1:0] rem_o
);
  logic          carry_w;
  logic [W-1:0]  shifted_w;

  always_comb begin
    carry_w   = |(rem_i & top_i);
    shifted_w = {rem_i[W-2:0], bit_i};
    rem_o     = (shifted_w ^ (carry_w ? poly_i : '0)) & mask_i;
  end
endmodule

// File: rtl/crcn_step_unit.sv
module crcn_step_unit
  import crcn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] ctrl,
  input  logic [WORD_W-1:0] data,
  input  logic [WORD_W-1:0] seed,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  logic              srst_n;
  crcn_state_e       state_q, state_d;
  crcn_job_t         job_q, job_d, dec_job;
  logic              job_en;
  logic              done_q, done_d;
  logic [WORD_W-1:0] result_q, result_d;
  logic              result_en;
  logic [CRC_MAX-1:0] step_rem;
  logic [CRC_MAX-1:0] final_rem;
  logic              take;

  crcn_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  crcn_cfg_decode u_dec (
    .ctrl_i (ctrl),
    .data_i (data),
    .seed_i (seed),
    .job_o  (dec_job)
  );

  crcn_div_step #(.W(CRC_MAX)) u_step (
    .rem_i  (job_q.rem),
    .poly_i (job_q.poly),
    .mask_i (job_q.mask),
    .top_i  (job_q.top),
    .bit_i  (job_q.feed[CHUNK_MAX-1]),
    .rem_o  (step_rem)
  );

  assign req_ready = (state_q == ST_IDLE) && srst_n;
  assign take      = req_valid && req_ready;
  assign final_rem = (job_q.inv ? ~step_rem : step_rem) & job_q.mask;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    job_d     = job_q;
    job_en    = 1'b0;
    done_d    = 1'b0;
    result_d  = result_q;
    result_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take) begin
          job_d   = dec_job;
          job_en  = 1'b1;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        job_en     = 1'b1;
        job_d.rem  = step_rem;
        job_d.feed = job_q.feed << 1;
        job_d.left = job_q.left - MW'(1);
        if (job_q.left == MW'(1)) begin
          state_d   = ST_IDLE;
          done_d    = 1'b1;
          result_d  = {{(WORD_W-CRC_MAX){1'b0}}, final_rem};
          result_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) job_q <= '0;
    else if (job_en) job_q <= job_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) result_q <= '0;
    else if (result_en) result_q <= result_d;
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/crcn_step_unit_chk.sv
module crcn_step_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] ctrl,
  input logic        done,
  input logic [31:0] result
);
  logic       pend_q;
  logic [3:0] elapsed_q;
  logic [3:0] lat_m_q;
  logic [4:0] lat_n_q;
  logic       take;

  assign take = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      elapsed_q <= '0;
      lat_m_q   <= '0;
      lat_n_q   <= '0;
    end else if (take) begin
      pend_q    <= 1'b1;
      elapsed_q <= '0;
      lat_m_q   <= {1'b0, ctrl[2:0]} + 4'd1;
      lat_n_q   <= {1'b0, ctrl[15:12]} + 5'd1;
    end else if (pend_q) begin
      elapsed_q <= elapsed_q + 4'd1;
      if (done) pend_q <= 1'b0;
    end
  end

  // R7: unit goes busy right after taking a request
  a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  // R7: the strobe only appears once the unit is idle again
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R8: strobe comes exactly m cycles after acceptance
  a_r8_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pend_q && elapsed_q == lat_m_q));

  a_r8_no_early_late: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && elapsed_q == lat_m_q) |-> done);

  // R8: result moves only with the strobe
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R1: nothing above the selected width
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((result >> lat_n_q) == 32'd0));
endmodule

bind crcn_step_unit crcn_step_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .ctrl      (ctrl),
  .done      (done),
  .result    (result)
);

// File: tb/tb_crcn_step_unit.sv
module tb_crcn_step_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] ctrl;
  logic [31:0] data;
  logic [31:0] seed;
  logic        done;
  logic [31:0] result;

  int tests_run;
  int tests_failed;
  bit finished;

  crcn_step_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ctrl      (ctrl),
    .data      (data),
    .seed      (seed),
    .done      (done),
    .result    (result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // bit-accurate model written from the requirements
  function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] d,
                                        input logic [31:0] s);
    int unsigned n, m;
    logic [31:0] mask, poly, chunk, rv, sd, rem, cp;
    n    = int'(c[15:12]) + 1;
    m    = int'(c[2:0]) + 1;
    mask = (32'h1 << n) - 32'h1;
    poly = (c >> 16) & mask;
    chunk = d & ((32'h1 << m) - 32'h1);
    if (c[8]) begin
      rv = '0;
      for (int i = 0; i < int'(m); i++) rv[i] = chunk[int'(m) - 1 - i];
      chunk = rv;
    end
    sd = s & mask;
    if (c[9]) sd = ~sd;
    if (m > n) rem = (chunk >> (m - n)) ^ sd;
    else       rem = (chunk << (n - m)) ^ sd;
    cp = chunk << n;
    for (int i = 0; i < int'(m); i++) begin
      logic hi;
      hi  = rem[n-1];
      rem = (rem << 1) | {31'b0, cp[m-1]};
      if (hi) rem = rem ^ poly;
      cp = cp << 1;
    end
    if (c[9]) rem = ~rem;
    return rem & mask;
  endfunction

  // issue one request; optionally keep offering other requests while busy
  task automatic run_job(input logic [31:0] c, input logic [31:0] d, input logic [31:0] s,
                         input bit hammer, output logic [31:0] res, output int lat);
    @(negedge clk);
    ctrl = c; data = d; seed = s; req_valid = 1'b1;
    @(negedge clk);
    lat = 1;
    if (hammer) begin
      ctrl = $urandom(); data = $urandom(); seed = $urandom();
    end else begin
      req_valid = 1'b0;
    end
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    res = result;
    lat = lat - 1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; ctrl = '0; data = '0; seed = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 done in reset", {31'b0, done}, 32'd0);
    check(result == 32'd0, "R9 result in reset", result, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9 ready after reset", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_known;
    logic [31:0] r; int lat;
    // n=4, poly 0x3, m=4, zero chunk, zero seed, inversion on -> 0xD
    run_job({16'h0003, 4'd3, 2'b00, 1'b1, 1'b0, 5'd0, 3'd3}, 32'h0, 32'h0, 1'b0, r, lat);
    check(r == 32'hD, "R5 inverted all-ones walk", r, 32'hD);
    check(lat == 4, "R8 latency m=4", lat, 32'd4);
    run_job({16'h0003, 4'd3, 2'b00, 1'b0, 1'b0, 5'd0, 3'd3}, 32'h0, 32'h0, 1'b0, r, lat);
    check(r == 32'h0, "R6 zero stays zero", r, 32'h0);
  endtask

  task automatic t_sweep;
    logic [31:0] r, c, d, s, e; int lat;
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 8; m++) begin
        for (int f = 0; f < 4; f++) begin
          c = $urandom();
          c[15:12] = n[3:0]; c[9:8] = f[1:0]; c[2:0] = m[2:0];
          d = $urandom(); s = $urandom();
          e = model(c, d, s);
          run_job(c, d, s, 1'b0, r, lat);
          check(r == e, "R6 R2 R4 R5 division vs model", r, e);
          check(lat == m + 1, "R8 latency sweep", lat, m + 1);
          check((r >> (n + 1)) == 32'd0, "R1 upper bits zero", r, 32'd0);
        end
      end
    end
  endtask

  task automatic t_chunk_ignore;
    logic [31:0] r1, r2, c; int lat;
    for (int m = 0; m < 8; m++) begin
      c = {16'hA5C3, 4'd9, 2'b00, 1'b0, 1'b1, 5'd0, m[2:0]};
      run_job(c, 32'h0000_005A & ((32'h1 << (m + 1)) - 1), 32'h1234, 1'b0, r1, lat);
      run_job(c, 32'hFFFF_FF5A | ((32'h1 << (m + 1)) - 1) & 32'h0000_005A
                 | ~((32'h1 << (m + 1)) - 1), 32'h1234, 1'b0, r2, lat);
      check(r1 == r2, "R3 data above chunk ignored", r2, r1);
    end
  endtask

  task automatic t_reverse;
    logic [31:0] r1, r2; int lat;
    run_job({16'h1021, 4'd15, 2'b00, 1'b0, 1'b1, 5'd0, 3'd7}, 32'h01, 32'hBEEF, 1'b0, r1, lat);
    run_job({16'h1021, 4'd15, 2'b00, 1'b0, 1'b0, 5'd0, 3'd7}, 32'h80, 32'hBEEF, 1'b0, r2, lat);
    check(r1 == r2, "R4 reversed 0x01 equals plain 0x80", r1, r2);
  endtask

  task automatic t_busy;
    logic [31:0] r, c, e, hold; int lat;
    c = {16'h8005, 4'd15, 2'b00, 1'b1, 1'b0, 5'd0, 3'd7};
    e = model(c, 32'h3C, 32'hFFFF);
    run_job(c, 32'h3C, 32'hFFFF, 1'b1, r, lat);
    check(r == e, "R7 offers during busy ignored", r, e);
    check(lat == 8, "R7 busy window m=8", lat, 32'd8);
    hold = result;
    @(negedge clk);
    check(done == 1'b0, "R7 no extra job after busy offers", {31'b0, done}, 32'd0);
    check(req_ready == 1'b1, "R7 idle after job", {31'b0, req_ready}, 32'd1);
    repeat (3) @(negedge clk);
    check(result == hold, "R8 result holds", result, hold);
  endtask

  initial begin
    tests_run = 0; tests_failed = 0; finished = 1'b0;
    t_reset();
    t_known();
    t_reverse();
    t_chunk_ignore();
    t_busy();
    t_sweep();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog R8 actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule